// File: doc/BRIEF.md
# UART FIFO DMA Ready Handshake Generator

This block drives the two active-low DMA request lines of a UART that has a transmit FIFO and a receive FIFO of equal depth (16 entries by default). It watches the occupancy counts of both FIFOs, a receive character-timeout flag and three configuration inputs: FIFO enable, DMA transfer mode, and a 2-bit receive trigger select. From these it decides when a DMA engine should move received bytes out or transmit bytes in.

There are two transfer modes. Single-transfer mode asks for one byte at a time: receive-ready is active while any byte is waiting, and transmit-ready is active while the transmit side is completely empty. Burst mode asks for a run of transfers. Receive-ready becomes active once the trigger level is reached or a timeout is flagged, and it stays active until the receive FIFO drains. Transmit-ready stays active until the transmit FIFO fills, and it becomes active again only once the FIFO is empty. When the FIFOs are disabled, so that one holding register stands in for each FIFO, single-transfer behaviour is used whatever the mode bit says.

Both outputs are registered. Each one reflects the inputs sampled at the previous rising clock edge.

Top module: `dma_ready_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, rx_ready_n is 1 and tx_ready_n is 0.
- R2: In single-transfer mode, rx_ready_n is 0 on the cycle after rx_count is nonzero and 1 on the cycle after rx_count is zero.
- R3: In burst mode, rx_ready_n goes to 0 on the cycle after rx_count reaches the trigger level. The trigger_sel encoding is 2'b00 for 1 byte, 2'b01 for 4, 2'b10 for 8 and 2'b11 for 14.
- R4: In burst mode, rx_timeout with a nonzero rx_count drives rx_ready_n to 0 on the next cycle. A timeout with rx_count zero leaves rx_ready_n at 1.
- R5: In burst mode, rx_ready_n returns to 1 only on the cycle after rx_count is zero. While the count is nonzero, below the trigger level and with no timeout, rx_ready_n keeps its previous value.
- R6: In single-transfer mode, tx_ready_n is 0 on the cycle after tx_count is zero and 1 on the cycle after tx_count is nonzero.
- R7: In burst mode, tx_ready_n goes to 1 on the cycle after tx_count equals the depth (16) and goes to 0 on the cycle after tx_count is zero. For counts in between it keeps its previous value.
- R8: Burst mode is selected only when fifo_en is 1 and burst_mode is 1. With fifo_en at 0, both outputs follow R2 and R6 regardless of burst_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 = FIFOs enabled, 0 = single holding register |
| burst_mode | input | 1 | 0 = single-transfer, 1 = burst (only when fifo_en is 1) |
| trigger_sel | input | 2 | Receive trigger level select (see R3) |
| rx_count | input | 5 | Receive FIFO occupancy, 0 to 16 |
| tx_count | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| rx_timeout | input | 1 | Receive character-timeout flag |
| rx_ready_n | output | 1 | Active-low receive DMA request |
| tx_ready_n | output | 1 | Active-low transmit DMA request |

## Verification
The only internal state is the two output flops. In burst mode each of them carries the memory of the last threshold crossing. A wrong held value shows at the port on the very next cycle. It persists while counts stay in the hold band, between empty and the trigger on the receive side and between empty and full on the transmit side. The bench therefore walks counts up through and down across those bands in every trigger setting and compares against its reference model on every clock, so a divergence is reported within one cycle of its cause.

// File: rtl/dma_rdy_pkg.sv
// Package: shared types and helpers for the DMA ready generator.
// Assumes FIFO depth is a multiple of 4 and at least 4.
package dma_rdy_pkg;

    // Effective transfer mode after FIFO-enable qualification.
    typedef enum logic {
        XFER_SINGLE = 1'b0,
        XFER_BURST  = 1'b1
    } xfer_mode_e;

    // Receive trigger level (in bytes) for a given select code and depth.
    function automatic int unsigned trig_bytes(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'b00:   return 1;
            2'b01:   return depth / 4;
            2'b10:   return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/dma_rdy_mode_sel.sv
// Module: dma_rdy_mode_sel
// Qualifies the burst-mode bit with FIFO enable. Burst signalling is only
// legal when FIFOs are on; otherwise single-transfer is forced.
module dma_rdy_mode_sel
    import dma_rdy_pkg::*;
(
    input  logic       fifo_en,
    input  logic       burst_mode,
    output xfer_mode_e mode
);

    // Combine the enable and the mode request into one effective mode.
    always_comb begin
        mode = (fifo_en && burst_mode) ? XFER_BURST : XFER_SINGLE;
    end

endmodule

// File: rtl/dma_rdy_trig_dec.sv
// Module: dma_rdy_trig_dec
// Decodes the 2-bit trigger select into a byte threshold sized to the
// count width. Assumes DEPTH fits in CW bits.
module dma_rdy_trig_dec
    import dma_rdy_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] level
);

    // Map the select code to a threshold count.
    always_comb begin
        level = CW'(trig_bytes(sel, DEPTH));
    end

endmodule

// File: rtl/dma_rdy_rx.sv
// Module: dma_rdy_rx
// Registered receive-ready generator. Single mode: active while any byte
// waits. Burst mode: set at trigger or on timeout, cleared only when empty.
// Assumes rx_count never exceeds DEPTH.
module dma_rdy_rx
    import dma_rdy_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xfer_mode_e    mode,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] level,
    input  logic          timeout,
    output logic          ready_n
);

    logic empty;
    logic reached;
    logic next_n;

    // Classify occupancy against empty and the trigger threshold.
    always_comb begin
        empty   = (count == '0);
        reached = (count >= level) || timeout;
    end

    // Choose the next output level from mode and occupancy.
    always_comb begin
        next_n = ready_n;
        if (mode == XFER_SINGLE) begin
            next_n = empty;
        end else if (empty) begin
            next_n = 1'b1;
        end else if (reached) begin
            next_n = 1'b0;
        end
    end

    // Hold the request line; reset to inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_n <= 1'b1;
        else        ready_n <= next_n;
    end

endmodule

// File: rtl/dma_rdy_tx.sv
// Module: dma_rdy_tx
// Registered transmit-ready generator. Single mode: active only when the
// transmit side is empty. Burst mode: active from empty until full.
// Assumes tx_count never exceeds DEPTH.
module dma_rdy_tx
    import dma_rdy_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xfer_mode_e    mode,
    input  logic [CW-1:0] count,
    output logic          ready_n
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic empty;
    logic full;
    logic next_n;

    // Classify occupancy at both ends of the FIFO.
    always_comb begin
        empty = (count == '0);
        full  = (count >= FULL_CNT);
    end

    // Choose the next output level from mode and occupancy.
    always_comb begin
        next_n = ready_n;
        if (mode == XFER_SINGLE) begin
            next_n = !empty;
        end else if (empty) begin
            next_n = 1'b0;
        end else if (full) begin
            next_n = 1'b1;
        end
    end

    // Hold the request line; reset to active (FIFO starts empty).
    always_ff @(posedge clk) begin
        if (!rst_n) ready_n <= 1'b0;
        else        ready_n <= next_n;
    end

endmodule

// File: rtl/dma_ready_gen.sv
// Module: dma_ready_gen (top)
// Generates the active-low receive and transmit DMA request lines from
// FIFO occupancy, configuration and the receive timeout flag.
// Assumes counts are driven by FIFOs of depth DEPTH in the same clock domain.
module dma_ready_gen
    import dma_rdy_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          burst_mode,
    input  logic [1:0]    trigger_sel,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          rx_timeout,
    output logic          rx_ready_n,
    output logic          tx_ready_n
);

    xfer_mode_e    mode;
    logic [CW-1:0] rx_level;

    dma_rdy_mode_sel u_mode (
        .fifo_en    (fifo_en),
        .burst_mode (burst_mode),
        .mode       (mode)
    );

    dma_rdy_trig_dec #(.DEPTH(DEPTH), .CW(CW)) u_trig (
        .sel   (trigger_sel),
        .level (rx_level)
    );

    dma_rdy_rx #(.CW(CW)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .count   (rx_count),
        .level   (rx_level),
        .timeout (rx_timeout),
        .ready_n (rx_ready_n)
    );

    dma_rdy_tx #(.DEPTH(DEPTH), .CW(CW)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .count   (tx_count),
        .ready_n (tx_ready_n)
    );

endmodule

// File: rtl/dma_ready_gen_chk.sv
// Module: dma_ready_gen_chk
// Property checker bound to dma_ready_gen; relates inputs at one edge to
// the request outputs at the next.
module dma_ready_gen_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          burst_mode,
    input logic [1:0]    trigger_sel,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic          rx_timeout,
    input logic          rx_ready_n,
    input logic          tx_ready_n
);

    logic          burst;
    logic [CW-1:0] thr;

    // Independent burst qualification and threshold table for the checks.
    always_comb begin
        burst = fifo_en & burst_mode;
        unique case (trigger_sel)
            2'd0: thr = CW'(1);
            2'd1: thr = CW'(DEPTH >> 2);
            2'd2: thr = CW'(DEPTH >> 1);
            2'd3: thr = CW'(DEPTH - 2);
        endcase
    end

    p_reset_vals_r1: assert property (@(posedge clk)
        !rst_n |=> (rx_ready_n && !tx_ready_n));

    p_rx_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !burst |=> (rx_ready_n == ($past(rx_count) == '0)));

    p_rx_trigger_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && rx_count >= thr) |=> !rx_ready_n);

    p_rx_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && rx_timeout && rx_count != '0) |=> !rx_ready_n);

    p_rx_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && rx_count == '0) |=> rx_ready_n);

    p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && rx_count != '0 && rx_count < thr && !rx_timeout)
        |=> (rx_ready_n == $past(rx_ready_n)));

    p_tx_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !burst |=> (tx_ready_n == ($past(tx_count) != '0)));

    p_tx_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && tx_count == CW'(DEPTH)) |=> tx_ready_n);

    p_tx_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && tx_count == '0) |=> !tx_ready_n);

    p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && tx_count != '0 && tx_count < CW'(DEPTH))
        |=> (tx_ready_n == $past(tx_ready_n)));

    p_fifo_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && burst_mode)
        |=> (rx_ready_n == ($past(rx_count) == '0)) && (tx_ready_n == ($past(tx_count) != '0)));

endmodule

bind dma_ready_gen dma_ready_gen_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en),
    .burst_mode  (burst_mode),
    .trigger_sel (trigger_sel),
    .rx_count    (rx_count),
    .tx_count    (tx_count),
    .rx_timeout  (rx_timeout),
    .rx_ready_n  (rx_ready_n),
    .tx_ready_n  (tx_ready_n)
);

// File: tb/test_dma_ready_gen.sv
// Bench for dma_ready_gen: behavioural reference model compared every clock.
module test_dma_ready_gen;

    localparam int CLK_P = 10;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       burst_mode = 1'b0;
    logic [1:0] trigger_sel = 2'd0;
    logic [4:0] rx_count = '0;
    logic [4:0] tx_count = '0;
    logic       rx_timeout = 1'b0;
    logic       rx_ready_n;
    logic       tx_ready_n;

    int    n_tests = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string cur_req = "R1";
    bit    done = 0;
    int    trig_tab[4] = '{1, 4, 8, 14};

    logic  m_rx = 1'b1;
    logic  m_tx = 1'b0;

    dma_ready_gen i_dma_ready_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_en     (fifo_en),
        .burst_mode  (burst_mode),
        .trigger_sel (trigger_sel),
        .rx_count    (rx_count),
        .tx_count    (tx_count),
        .rx_timeout  (rx_timeout),
        .rx_ready_n  (rx_ready_n),
        .tx_ready_n  (tx_ready_n)
    );

    always #(CLK_P/2) clk = ~clk;

    // Reference model of the request lines.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_rx <= 1'b1;
            m_tx <= 1'b0;
        end else if (!(fifo_en && burst_mode)) begin
            m_rx <= (rx_count == 0);
            m_tx <= (tx_count != 0);
        end else begin
            if (rx_count == 0) m_rx <= 1'b1;
            else if (int'(rx_count) >= trig_tab[trigger_sel] || rx_timeout) m_rx <= 1'b0;
            if (tx_count == 0) m_tx <= 1'b0;
            else if (int'(tx_count) == DEPTH) m_tx <= 1'b1;
        end
    end

    // Compare outputs with the model at every falling edge.
    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            n_tests++;
            if (rx_ready_n !== m_rx || tx_ready_n !== m_tx) begin
                n_fail++;
                $display("FAIL %s cycle %0d: rx_ready_n=%b tx_ready_n=%b expected rx=%b tx=%b",
                         cur_req, cyc, rx_ready_n, tx_ready_n, m_rx, m_tx);
            end
        end
    end

    // Advance one cycle; inputs change a quarter period after the edge.
    task automatic tick();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic drive(input logic [4:0] rc, input logic [4:0] tc, input logic to);
        rx_count   = rc;
        tx_count   = tc;
        rx_timeout = to;
        tick();
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: actual hung, expected completion");
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        cur_req = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R2, R6: single-transfer mode with FIFOs on
        fifo_en = 1'b1; burst_mode = 1'b0;
        cur_req = "R2";
        drive(0, 0, 0); drive(1, 0, 0); drive(3, 0, 1); drive(0, 0, 1); drive(16, 0, 0); drive(0, 0, 0);
        cur_req = "R6";
        drive(0, 1, 0); drive(0, 16, 0); drive(0, 5, 0); drive(0, 0, 0); drive(0, 2, 0);
        drive(0, 0, 0);

        // R3, R5: burst mode, every trigger setting, up then down
        burst_mode = 1'b1;
        for (int s = 0; s < 4; s++) begin
            trigger_sel = s[1:0];
            cur_req = "R3";
            for (int c = 0; c <= trig_tab[s]; c++) drive(c[4:0], 0, 0);
            drive(16, 0, 0);
            cur_req = "R5";
            for (int c = 15; c >= 0; c--) drive(c[4:0], 0, 0);
            if (trig_tab[s] > 1) drive(1, 0, 0);
            drive(0, 0, 0);
        end

        // R4: timeout below trigger, then timeout while empty
        cur_req = "R4";
        trigger_sel = 2'b11;
        drive(2, 0, 0); drive(2, 0, 1); drive(3, 0, 0); drive(0, 0, 0);
        drive(0, 0, 1); drive(1, 0, 0); drive(1, 0, 1); drive(0, 0, 0);

        // R7: transmit burst hysteresis
        cur_req = "R7";
        for (int c = 0; c <= 16; c++) drive(0, c[4:0], 0);
        for (int c = 15; c >= 0; c--) drive(0, c[4:0], 0);
        drive(0, 8, 0); drive(0, 0, 0);

        // R8: FIFOs off forces single-transfer behaviour
        cur_req = "R8";
        fifo_en = 1'b0; burst_mode = 1'b1; trigger_sel = 2'b11;
        drive(1, 0, 0); drive(0, 1, 0); drive(1, 1, 1); drive(0, 0, 0); drive(0, 1, 0);
        drive(0, 0, 0);

        // R1: reset in the middle of burst state
        cur_req = "R1";
        fifo_en = 1'b1;
        drive(16, 16, 0); drive(5, 5, 0);
        rst_n = 1'b0; tick(); tick();
        rst_n = 1'b1; drive(5, 5, 0); drive(0, 0, 0);

        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule